// File: doc/BRIEF.md
# Serial I/Q Stream Transmitter

This block turns a stream of 16-bit I/Q sample pairs into a one-bit serial line with a matching frame strobe. The line advances one bit on every cycle of the block clock, which is treated as the serial bit clock. Each accepted pair goes out as a 32-bit frame. The I word is sent first and the Q word follows at once, each starting from its most significant bit. The strobe is generated in step with the data and marks where each frame starts.

A two-bit rate input sets how many bit-clock cycles one frame occupies: 32, 64, 128 or 256. The 32 data cycles always come first, and the rest of the frame is padding with the line and strobe low. Because of this, the sample cadence stays the same while the bit clock runs at 1×, 2×, 4× or 8× the base rate.

Samples come in on a valid/ready handshake. Ready is raised only in the last cycle of each frame, so a new sample is taken only at a frame boundary. If no sample is offered at that boundary, the next frame is sent entirely idle. A second input selects the shape of the strobe: a single-cycle pulse on the first I bit, or a level that covers the whole I word. The rate and the strobe shape are both captured at the boundary and stay fixed for the frame that follows.

Top module: `iq_serial_tx`

## Requirements
- R1: After a handshake, `ser_data` carries I bit 15 down to I bit 0 and then Q bit 15 down to Q bit 0, one bit per cycle. The first bit appears in the cycle right after the handshake edge.
- R2: The frame length in cycles is set by the captured `rate_sel`: 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256. `s_ready` is high exactly once per frame.
- R3: In the padding cycles that follow the 32 data cycles, `ser_data` and `ser_strobe` are both 0.
- R4: With `strobe_level` captured as 0, `ser_strobe` is high only in the cycle that carries I bit 15.
- R5: With `strobe_level` captured as 1, `ser_strobe` is high for the 16 I-bit cycles and low for the 16 Q-bit cycles.
- R6: `s_ready` is high only in the last cycle of a frame. A sample is taken only when `s_valid` and `s_ready` are both high, and `s_valid`, `s_i` and `s_q` have no effect on the outputs in any other cycle.
- R7: If `s_valid` is low while `s_ready` is high, the whole next frame is idle: `ser_data` and `ser_strobe` stay 0 for its full length.
- R8: `rate_sel` and `strobe_level` are captured only in the `s_ready` cycle. Changes in other cycles do not affect the current frame's length or strobe shape.
- R9: While reset is held, and in the first cycle after it is released, `s_ready` is 1 and `ser_data` and `ser_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Clock multiple for the next frame (0:1×, 1:2×, 2:4×, 3:8×) |
| strobe_level | input | 1 | Strobe shape for the next frame (0: pulse, 1: level over the I word) |
| s_valid | input | 1 | Sample pair offered |
| s_i | input | 16 | I component of the offered sample |
| s_q | input | 16 | Q component of the offered sample |
| s_ready | output | 1 | High in the last cycle of a frame; the sample is taken in that cycle |
| ser_data | output | 1 | Serial data, most significant bit first |
| ser_strobe | output | 1 | Frame strobe |

## Verification
The assertions assume that `rate_sel` and `strobe_level` matter only in the `s_ready` cycle, and that `s_valid` may be high at any time without being taken. The stimulus keeps the captured values known by holding the chosen rate and strobe shape at each boundary. In every other cycle it deliberately drives random values on `rate_sel`, `strobe_level`, `s_valid` and the sample inputs. Each expected frame is built from the requirements alone: the 32 bits, the strobe shape and the padding length all come from the values present at the boundary.

// File: rtl/iq_serial_pkg.sv
// Package: shared types and helpers for the serial I/Q transmitter.
// Assumes frame length is two sample words times a power-of-two multiple.
package iq_serial_pkg;

    typedef enum logic [1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2,
        RATE_X8 = 2'd3
    } rate_e;

    // Number of bit-clock cycles in one frame for a given multiple.
    function automatic int unsigned frame_cycles(input int unsigned sample_w,
                                                 input rate_e rate);
        return (2 * sample_w) << rate;
    endfunction

endpackage

// File: rtl/iq_frame_timer.sv
// Frame timer: counts bit-clock cycles within a frame and captures the
// rate multiple at each frame boundary.
// Assumes: counter wide enough for the longest frame (set by the parent).
module iq_frame_timer
    import iq_serial_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last,
    output logic [1:0]       rate_q
);

    rate_e            rate_r;
    logic [CNT_W-1:0] last_idx;

    // Last index of the current frame, from the captured rate.
    always_comb begin
        last_idx = CNT_W'(frame_cycles(SAMPLE_W, rate_r) - 1);
    end

    assign at_last = (cnt == last_idx);
    assign rate_q  = rate_r;

    // Advance the cycle count; wrap and capture the rate at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_r <= RATE_X1;
            cnt    <= CNT_W'(frame_cycles(SAMPLE_W, RATE_X1) - 1);
        end else if (at_last) begin
            rate_r <= rate_e'(rate_sel);
            cnt    <= '0;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_last |=> (cnt == '0));

endmodule

// File: rtl/iq_shift_out.sv
// Shift register: loads a packed I/Q word and moves it out MSB first,
// shifting zeros in behind so it drains to zero after one word.
module iq_shift_out #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              msb
);

    logic [WORD_W-1:0] sh_q;

    // Load a new word or shift one place toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= word;
        end else begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[WORD_W-1];

endmodule

// File: rtl/iq_strobe_gen.sv
// Strobe generator: captures the strobe shape at each frame boundary and
// derives the strobe from the in-frame cycle count.
// Assumes cnt restarts at zero on the cycle after the boundary.
module iq_strobe_gen #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_last,
    input  logic             level_sel,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    output logic             strobe,
    output logic             level_q
);

    // Capture the strobe shape at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else if (at_last) begin
            level_q <= level_sel;
        end
    end

    // Pulse on the first bit, or a level over the I word.
    always_comb begin
        if (!active) begin
            strobe = 1'b0;
        end else if (level_q) begin
            strobe = (cnt < CNT_W'(SAMPLE_W));
        end else begin
            strobe = (cnt == '0);
        end
    end

endmodule

// File: rtl/iq_serial_tx.sv
// Serial I/Q transmitter top: takes one sample per frame on a valid/ready
// handshake and sends I then Q MSB first, padding each frame for the
// chosen bit-clock multiple.
// Assumes clk is the serial bit clock; no clock generation is done here.
module iq_serial_tx
    import iq_serial_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int MAX_MULT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          rate_sel,
    input  logic                strobe_level,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_i,
    input  logic [SAMPLE_W-1:0] s_q,
    output logic                s_ready,
    output logic                ser_data,
    output logic                ser_strobe
);

    localparam int WORD_W = 2 * SAMPLE_W;
    localparam int CNT_W  = $clog2(WORD_W * MAX_MULT);

    logic [CNT_W-1:0] cnt;
    logic             at_last;
    logic [1:0]       rate_q;
    logic             level_q;
    logic             active_q;
    logic             take;
    logic             msb;

    assign take    = at_last && s_valid;
    assign s_ready = at_last;

    iq_frame_timer #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .cnt(cnt), .at_last(at_last), .rate_q(rate_q)
    );

    iq_shift_out #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(take),
        .word({s_i, s_q}), .msb(msb)
    );

    iq_strobe_gen #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .at_last(at_last),
        .level_sel(strobe_level), .active(active_q), .cnt(cnt),
        .strobe(ser_strobe), .level_q(level_q)
    );

    // Mark whether the frame being sent carries a sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (at_last) begin
            active_q <= s_valid;
        end
    end

    // Data only within the 32 data cycles of a carrying frame.
    assign ser_data = active_q && (cnt < CNT_W'(WORD_W)) && msb;

    // R1
    first_bit_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> ser_strobe);

    // R3
    pad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CNT_W'(WORD_W)) |-> (!ser_data && !ser_strobe));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_strobe && !level_q) |=> !ser_strobe);

    // R5
    level_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ser_strobe) && level_q) |-> (cnt == CNT_W'(SAMPLE_W)));

    // R6
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R7
    idle_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> (!ser_data && !ser_strobe));

    // R8
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready |=> $stable(rate_q));

endmodule

// File: tb/iq_serial_tx_test.sv
// Scoreboard bench: the driver pushes the expected per-cycle (data, strobe)
// pairs for each frame; the monitor pops and compares every cycle.
module iq_serial_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        strobe_level = 1'b0;
    logic        s_valid = 1'b0;
    logic [15:0] s_i = '0;
    logic [15:0] s_q = '0;
    logic        s_ready;
    logic        ser_data;
    logic        ser_strobe;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [1:0] expq[$];

    always #2.5 clk = ~clk;

    iq_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .strobe_level(strobe_level), .s_valid(s_valid), .s_i(s_i), .s_q(s_q),
        .s_ready(s_ready), .ser_data(ser_data), .ser_strobe(ser_strobe)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge where s_ready is expected high; returns at the
    // negedge of the next boundary.
    task automatic send_frame(input bit vld, input logic [15:0] i, input logic [15:0] q,
                              input logic [1:0] rate, input bit lvl);
        int len;
        logic [31:0] w;
        len = 32 << rate;
        w = {i, q};
        s_valid = vld; s_i = i; s_q = q; rate_sel = rate; strobe_level = lvl;
        check(s_ready === 1'b1, "R6 ready at boundary", 8'(s_ready), 8'd1);
        @(posedge clk);
        for (int k = 0; k < len; k++) begin
            logic d, s;
            d = vld && (k < 32) && w[31-k];                   // R1 R3 R7
            s = vld && (lvl ? (k < 16) : (k == 0));           // R4 R5
            expq.push_back({d, s});
        end
        for (int k = 1; k < len; k++) begin
            @(negedge clk);
            check(s_ready === 1'b0, "R2 R6 ready low mid-frame", 8'(s_ready), 8'd0);
            // R8 R6: junk on inputs that must be ignored mid-frame
            rate_sel = 2'($urandom); strobe_level = 1'($urandom);
            s_valid = 1'($urandom); s_i = 16'($urandom); s_q = 16'($urandom);
        end
        @(negedge clk);
    endtask

    // Monitor: compare one expected (data, strobe) pair per cycle.
    always @(negedge clk) begin
        if (rst_n && expq.size() > 0) begin
            logic [1:0] e;
            e = expq.pop_front();
            check({ser_data, ser_strobe} === e, "R1-frame data/strobe R3 R4 R5 R7",
                  8'({ser_data, ser_strobe}), 8'(e));
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(s_ready === 1'b1 && ser_data === 1'b0 && ser_strobe === 1'b0,
              "R9 reset", 8'({s_ready, ser_data, ser_strobe}), 8'b100);
        rst_n = 1'b1;
        check(s_ready === 1'b1 && ser_data === 1'b0 && ser_strobe === 1'b0,
              "R9 after release", 8'({s_ready, ser_data, ser_strobe}), 8'b100);
        // 1x back-to-back, pulse strobe
        send_frame(1, 16'h8001, 16'h7FFE, 2'd0, 0);
        send_frame(1, 16'hFFFF, 16'h0000, 2'd0, 0);
        send_frame(1, 16'hA5A5, 16'h5A5A, 2'd0, 1);
        // idle frames at several rates (R7)
        send_frame(0, 16'hFFFF, 16'hFFFF, 2'd0, 1);
        send_frame(0, 16'hFFFF, 16'hFFFF, 2'd1, 0);
        // R2 each rate
        send_frame(1, 16'h1234, 16'hABCD, 2'd1, 0);
        send_frame(1, 16'hC3C3, 16'h0F0F, 2'd2, 1);
        send_frame(1, 16'h0001, 16'h8000, 2'd3, 0);
        send_frame(1, 16'hDEAD, 16'hBEEF, 2'd3, 1);
        send_frame(0, 16'h0000, 16'h0000, 2'd2, 0);
        send_frame(1, 16'hFFFF, 16'hFFFF, 2'd2, 1);
        for (int n = 0; n < 12; n++)
            send_frame(1'($urandom), 16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom));
        send_frame(1, 16'h0F0F, 16'hF0F0, 2'd0, 0);
        s_valid = 1'b0;
        rate_sel = 2'd0;
        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R2 scoreboard drained", 8'(expq.size()), 8'd0);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule